// File: doc/BRIEF.md
# Indexed Configuration Register Bank

This block gives a chipset a small bank of configuration registers that sit behind two byte-wide I/O ports. Software first writes a register number to the index port. It then reads or writes that register through the data port. The index stays latched between accesses, so one selection can serve several data-port reads and writes.

Sixteen of the 256 possible register numbers are backed by storage. Each of them keeps only its writable bits. All other bits are held at zero, and each register has its own reset value. Data writes to register numbers that have no storage are discarded.

Three shadow-control registers are brought out as parallel buses for the memory decoder. Two bits of the miscellaneous-control register are brought out as enables for the alternate A20 gate and for the fast-reset logic.

Top module: `cfg_regbank`

## Requirements
- R1: A write strobe with address 0x0022 (the index port) loads the 8-bit write data into the index latch on that clock edge. The latch keeps its value until the next index-port write or until reset.
- R2: A write strobe with address 0x0023 (the data port) stores the write data ANDed with the mask of the selected register. The masks, by register number, are:
  - 0x05: 0x3F
  - 0x06: 0xBC
  - 0x07: 0x0F
  - 0x10: 0x3D
  - 0x11, 0x12 and 0x13: 0x8D
  - 0x14 to 0x17: 0x7F
  - 0x18: 0xF3
  - 0x19 and 0x1A: 0x7F
  - 0x1B: 0xFF
  - 0x1C: 0xB3
- R3: A read strobe at the data port returns the selected register in the same cycle. Bits outside that register's mask read as zero.
- R4: A data-port write to any register number not listed in R2 changes no register. Reads of such a register number return 0x00.
- R5: A read strobe at the index port returns 0xFF. When no read strobe is present at either port, the read data is 0x00.
- R6: While reset is asserted, every register is zero except two. Register 0x05 resets to 0x05 and register 0x1B resets to 0x60. The index latch resets to 0x00.
- R7: The outputs shadow_seg, shadow_rden and shadow_wren carry registers 0x18, 0x19 and 0x19's neighbour 0x1A, respectively. Each takes its new value on the clock edge of the data-port write.
- R8: Output a20_fast_en equals bit 4 of register 0x1C, and output rst_fast_en equals bit 5 of it. Both change on the clock edge of the data-port write.
- R9: Read or write strobes at any address other than 0x0022 and 0x0023 change neither the index latch nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It is asserted asynchronously and released synchronously to clk. |
| io_addr | input | 16 | I/O address of the current strobe |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_rdata | output | 8 | Read data. It is combinational and valid while io_rd is high. |
| shadow_seg | output | 8 | Contents of register 0x18 |
| shadow_rden | output | 8 | Contents of register 0x19 |
| shadow_wren | output | 8 | Contents of register 0x1A |
| a20_fast_en | output | 1 | Alternate A20 gate enable, from bit 4 of register 0x1C |
| rst_fast_en | output | 1 | Fast reset enable, from bit 5 of register 0x1C |

## Verification
The properties assume that io_wr and io_rd are never high in the same cycle. They also assume that strobes only arrive once reset has been released. The bench drives each strobe alone, for exactly one cycle between falling edges, and never while rst_n is low. It sweeps all 256 index values with several data patterns, so that every mask bit and every unbacked index is covered. It then reads the bus outputs back half a cycle after each write edge.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  localparam int REG_W  = 8;
  localparam int NSLOT  = 16;

  typedef logic [REG_W-1:0] reg_t;

  typedef enum logic [1:0] {
    RSEL_NONE  = 2'd0,
    RSEL_INDEX = 2'd1,
    RSEL_DATA  = 2'd2
  } rsel_e;

  // Slot s occupies bits [s*8 +: 8]; slot 0 is the rightmost byte.
  localparam logic [NSLOT*REG_W-1:0] SLOT_NUM_V = {
    8'h1C, 8'h1B, 8'h1A, 8'h19, 8'h18, 8'h17, 8'h16, 8'h15,
    8'h14, 8'h13, 8'h12, 8'h11, 8'h10, 8'h07, 8'h06, 8'h05};

  localparam logic [NSLOT*REG_W-1:0] SLOT_MASK_V = {
    8'hB3, 8'hFF, 8'h7F, 8'h7F, 8'hF3, 8'h7F, 8'h7F, 8'h7F,
    8'h7F, 8'h8D, 8'h8D, 8'h8D, 8'h3D, 8'h0F, 8'hBC, 8'h3F};

  localparam logic [NSLOT*REG_W-1:0] SLOT_RST_V = {
    8'h00, 8'h60, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
    8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h05};

  function automatic reg_t slot_num(input int s);
    return SLOT_NUM_V[s*REG_W +: REG_W];
  endfunction

  function automatic reg_t slot_mask(input int s);
    return SLOT_MASK_V[s*REG_W +: REG_W];
  endfunction

  function automatic reg_t slot_rst(input int s);
    return SLOT_RST_V[s*REG_W +: REG_W];
  endfunction

  // Slot holding a register number, or -1 when the number is unbacked.
  function automatic int slot_of(input reg_t num);
    int r;
    r = -1;
    for (int s = 0; s < NSLOT; s++) begin
      if (slot_num(s) == num) r = s;
    end
    return r;
  endfunction

  function automatic logic is_backed(input reg_t num);
    return slot_of(num) >= 0;
  endfunction

  function automatic reg_t mask_of(input reg_t num);
    reg_t m;
    m = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (slot_num(s) == num) m = slot_mask(s);
    end
    return m;
  endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfgbank_pkg::*;
#(
  parameter int               ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h0023
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              idx_we,
  output logic              dat_we,
  output rsel_e             rsel
);

  logic hit_index;
  logic hit_data;

  always_comb begin
    hit_index = (io_addr == INDEX_PORT);
    hit_data  = (io_addr == DATA_PORT);
  end

  always_comb begin
    idx_we = io_wr && hit_index;
    dat_we = io_wr && hit_data;
  end

  always_comb begin
    rsel = RSEL_NONE;
    if (io_rd) begin
      if (hit_index)     rsel = RSEL_INDEX;
      else if (hit_data) rsel = RSEL_DATA;
    end
  end

endmodule

// File: rtl/cfg_index_reg.sv
module cfg_index_reg
  import cfgbank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  reg_t wdata,
  output reg_t idx_q
);

  reg_t idx_d;

  always_comb begin
    idx_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  idx_q <= '0;
    else if (we) idx_q <= idx_d;
  end

endmodule

// File: rtl/cfg_reg_slot.sv
module cfg_reg_slot
  import cfgbank_pkg::*;
#(
  parameter reg_t MASK = 8'hFF,
  parameter reg_t RSTV = 8'h00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  reg_t wdata,
  output reg_t q
);

  reg_t q_d;

  always_comb begin
    q_d = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RSTV & MASK;
    else if (we) q <= q_d;
  end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfgbank_pkg::*;
(
  input  logic [NSLOT-1:0][REG_W-1:0] slot_q,
  input  reg_t                        idx_q,
  input  rsel_e                       rsel,
  output reg_t                        rdata
);

  reg_t sel_val;

  always_comb begin
    sel_val = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (idx_q == slot_num(s)) sel_val = slot_q[s];
    end
  end

  always_comb begin
    unique case (rsel)
      RSEL_INDEX: rdata = '1;
      RSEL_DATA:  rdata = sel_val;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfgbank_pkg::*;
#(
  parameter int               ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h0023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  output logic [7:0]        shadow_seg,
  output logic [7:0]        shadow_rden,
  output logic [7:0]        shadow_wren,
  output logic              a20_fast_en,
  output logic              rst_fast_en
);

  localparam int S_SEG  = slot_of(8'h18);
  localparam int S_RDEN = slot_of(8'h19);
  localparam int S_WREN = slot_of(8'h1A);
  localparam int S_MISC = slot_of(8'h1C);
  localparam int B_A20  = 4;
  localparam int B_RST  = 5;

  logic                        idx_we;
  logic                        dat_we;
  rsel_e                       rsel;
  reg_t                        idx_q;
  logic [NSLOT-1:0][REG_W-1:0] slot_q;

  cfg_port_decode #(
    .ADDR_W    (ADDR_W),
    .INDEX_PORT(INDEX_PORT),
    .DATA_PORT (DATA_PORT)
  ) u_dec (
    .io_addr(io_addr),
    .io_wr  (io_wr),
    .io_rd  (io_rd),
    .idx_we (idx_we),
    .dat_we (dat_we),
    .rsel   (rsel)
  );

  cfg_index_reg u_idx (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (idx_we),
    .wdata(io_wdata),
    .idx_q(idx_q)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic slot_we;
    always_comb slot_we = dat_we && (idx_q == slot_num(s));

    cfg_reg_slot #(
      .MASK(slot_mask(s)),
      .RSTV(slot_rst(s))
    ) u_slot (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (slot_we),
      .wdata(io_wdata),
      .q    (slot_q[s])
    );
  end

  cfg_read_mux u_rmux (
    .slot_q(slot_q),
    .idx_q (idx_q),
    .rsel  (rsel),
    .rdata (io_rdata)
  );

  always_comb begin
    shadow_seg  = slot_q[S_SEG];
    shadow_rden = slot_q[S_RDEN];
    shadow_wren = slot_q[S_WREN];
    a20_fast_en = slot_q[S_MISC][B_A20];
    rst_fast_en = slot_q[S_MISC][B_RST];
  end

endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk
  import cfgbank_pkg::*;
#(
  parameter int               ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h0023
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_rdata,
  input logic [7:0]        idx_q,
  input logic [7:0]        shadow_seg,
  input logic [7:0]        shadow_rden,
  input logic [7:0]        shadow_wren,
  input logic              a20_fast_en,
  input logic              rst_fast_en
);

  logic at_index;
  logic at_data;
  logic at_stray;

  always_comb begin
    at_index = (io_addr == INDEX_PORT);
    at_data  = (io_addr == DATA_PORT);
    at_stray = !at_index && !at_data;
  end

  // R1
  idx_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && at_index |=> idx_q == $past(io_wdata));

  // R5
  idx_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && at_index |-> io_rdata == 8'hFF);

  // R5
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'h00);

  // R3
  masked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && at_data |-> (io_rdata & ~mask_of(idx_q)) == 8'h00);

  // R7
  seg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && at_data && idx_q == 8'h18 |=> shadow_seg == ($past(io_wdata) & 8'hF3));

  // R7
  rden_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && at_data && idx_q == 8'h19 |=> shadow_rden == ($past(io_wdata) & 8'h7F));

  // R8
  feature_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && at_data && idx_q == 8'h1C |=>
      a20_fast_en == $past(io_wdata[4]) && rst_fast_en == $past(io_wdata[5]));

  // R4
  unbacked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && at_data && !is_backed(idx_q) |=>
      $stable(shadow_seg) && $stable(shadow_rden) && $stable(shadow_wren) &&
      $stable(a20_fast_en) && $stable(rst_fast_en));

  // R9
  stray_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr || io_rd) && at_stray |=>
      $stable(idx_q) && $stable(shadow_seg) && $stable(shadow_rden) &&
      $stable(shadow_wren) && $stable(a20_fast_en) && $stable(rst_fast_en));

endmodule

bind cfg_regbank cfg_regbank_chk #(
  .ADDR_W    (ADDR_W),
  .INDEX_PORT(INDEX_PORT),
  .DATA_PORT (DATA_PORT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_addr    (io_addr),
  .io_wdata   (io_wdata),
  .io_wr      (io_wr),
  .io_rd      (io_rd),
  .io_rdata   (io_rdata),
  .idx_q      (idx_q),
  .shadow_seg (shadow_seg),
  .shadow_rden(shadow_rden),
  .shadow_wren(shadow_wren),
  .a20_fast_en(a20_fast_en),
  .rst_fast_en(rst_fast_en)
);

// File: tb/tb_cfg_regbank.sv
module tb_cfg_regbank;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk;
  logic        rst_n;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic        io_wr;
  logic        io_rd;
  logic [7:0]  io_rdata;
  logic [7:0]  shadow_seg;
  logic [7:0]  shadow_rden;
  logic [7:0]  shadow_wren;
  logic        a20_fast_en;
  logic        rst_fast_en;

  int total;
  int bad;
  bit done;

  cfg_regbank dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_rdata   (io_rdata),
    .shadow_seg (shadow_seg),
    .shadow_rden(shadow_rden),
    .shadow_wren(shadow_wren),
    .a20_fast_en(a20_fast_en),
    .rst_fast_en(rst_fast_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_mask(input logic [7:0] n);
    case (n)
      8'h05: return 8'h3F;
      8'h06: return 8'hBC;
      8'h07: return 8'h0F;
      8'h10: return 8'h3D;
      8'h11, 8'h12, 8'h13: return 8'h8D;
      8'h14, 8'h15, 8'h16, 8'h17: return 8'h7F;
      8'h18: return 8'hF3;
      8'h19, 8'h1A: return 8'h7F;
      8'h1B: return 8'hFF;
      8'h1C: return 8'hB3;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_rst(input logic [7:0] n);
    if (n == 8'h05) return 8'h05;
    if (n == 8'h1B) return 8'h60;
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0000; io_wdata = 8'h00;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0; io_addr = 16'h0000;
  endtask

  task automatic read_reg(input logic [7:0] n, output logic [7:0] d);
    io_write(16'h0022, n);
    io_read(16'h0023, d);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog got=00 exp=01");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic [7:0] pats [4];
    total = 0; bad = 0; done = 0;
    pats[0] = 8'hFF; pats[1] = 8'h00; pats[2] = 8'hA5; pats[3] = 8'h5A;
    rst_n = 1'b0; io_addr = '0; io_wdata = '0; io_wr = 0; io_rd = 0;
    repeat (3) @(negedge clk);
    check("R6 seg", shadow_seg, 8'h00);
    check("R6 rden", shadow_rden, 8'h00);
    check("R6 wren", shadow_wren, 8'h00);
    check("R8 a20", {7'd0, a20_fast_en}, 8'h00);
    rst_n = 1'b1;
    #1 check("R5 idle", io_rdata, 8'h00);

    // R6 defaults across every index
    for (int n = 0; n < 256; n++) begin
      read_reg(8'(n), v);
      check("R6 default", v, exp_rst(8'(n)));
    end

    // R5 index port reads all ones
    io_read(16'h0022, v);
    check("R5 index read", v, 8'hFF);

    // R1 R2 R3 R4 R7 R8 sweeps
    foreach (pats[p]) begin
      for (int n = 0; n < 256; n++) begin
        io_write(16'h0022, 8'(n));
        io_write(16'h0023, pats[p]);
        if (n == 8'h18) check("R7 seg", shadow_seg, pats[p] & 8'hF3);
        if (n == 8'h19) check("R7 rden", shadow_rden, pats[p] & 8'h7F);
        if (n == 8'h1A) check("R7 wren", shadow_wren, pats[p] & 8'h7F);
        if (n == 8'h1C) begin
          check("R8 a20", {7'd0, a20_fast_en}, {7'd0, pats[p][4]});
          check("R8 rst", {7'd0, rst_fast_en}, {7'd0, pats[p][5]});
        end
        io_read(16'h0023, v);
        check("R2 R3 R1 readback", v, pats[p] & exp_mask(8'(n)));
      end
    end

    // R4 unbacked writes leave stored values alone
    io_write(16'h0022, 8'h1B); io_write(16'h0023, 8'h3C);
    io_write(16'h0022, 8'h18); io_write(16'h0023, 8'h81);
    io_write(16'h0022, 8'h08); io_write(16'h0023, 8'hFF);
    io_write(16'h0022, 8'h1D); io_write(16'h0023, 8'hFF);
    io_write(16'h0022, 8'hFF); io_write(16'h0023, 8'hFF);
    check("R4 seg kept", shadow_seg, 8'h81);
    read_reg(8'h1B, v);
    check("R4 1B kept", v, 8'h3C);
    read_reg(8'h1D, v);
    check("R4 unbacked read", v, 8'h00);

    // R9 strays: index stays 0x18 and nothing changes
    io_write(16'h0022, 8'h18);
    io_write(16'h0024, 8'h1B);
    io_write(16'h0122, 8'h1B);
    io_write(16'h0123, 8'h00);
    io_write(16'h0021, 8'h00);
    io_read(16'h0024, v);
    check("R9 stray read", v, 8'h00);
    check("R9 seg kept", shadow_seg, 8'h81);
    io_read(16'h0023, v);
    check("R9 R1 index kept", v, 8'h81);

    // R6 reset during operation
    io_write(16'h0022, 8'h05); io_write(16'h0023, 8'h3F);
    @(negedge clk); rst_n = 1'b0;
    #1 check("R6 seg async", shadow_seg, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    io_read(16'h0023, v);
    check("R6 R1 index cleared", v, 8'h00);
    read_reg(8'h05, v);
    check("R6 05 again", v, 8'h05);
    read_reg(8'h1B, v);
    check("R6 1B again", v, 8'h60);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule